// File: doc/BRIEF.md
# Mode-Selectable External Data Port Register

This block is one register slice of a host-bus card-socket controller. The host reaches it through an indexed I/O window of two addresses. The address with `io_a0` low holds a primary index. The address with `io_a0` high is the data window for whatever register that index selects. Primary index 6Eh selects an extended-index register. Primary index 6Fh together with the extended index opens either an 8-bit external-data register (extended index 0Ah) or its mode-control register (extended index 0Bh).

Two bits of the control register pick how the external-data register behaves:

- **Scratchpad/status mode.** The register holds a writable nibble and the synchronized voltage-sense levels of two sockets.
- **Read-port mode.** A host read of the register drives an active-low general-purpose strobe. That strobe serves as the output enable of an external buffer that places its byte on the high data lane.
- **Write-latch mode.** A host write drives the same strobe, so the high data byte can be latched into an external register. The block keeps a copy of that byte, and reads of the register return it.

Top module: `xdata_port`

## Requirements
- R1: After a synchronous active-low reset, the primary index, extended index, control register, scratch nibble and latch copy are all 0, and `gp_strobe_n` is high.
- R2: A write with `io_a0`=0 loads the primary index. A read with `io_a0`=0 returns the primary index. With primary index 6Eh, a data-window write loads the extended index and a data-window read returns it.
- R3: With primary index 6Fh and extended index 0Bh, the data window reads and writes an 8-bit control register. The mode field is {bit 4, bit 3}: 00 selects scratchpad/status, 01 selects read-port, 10 selects write-latch, and 11 is reserved.
- R4: In scratchpad/status mode, a read of the data register (6Fh/0Ah) returns {scratch[3:0], vs_b_n[1:0], vs_a_n[1:0]}. A write stores bits 7:4 as scratch, and written bits 3:0 have no effect.
- R5: A change on a voltage-sense pin appears in read data after the second rising clock edge and not after the first.
- R6: In read-port mode, `gp_strobe_n` is low only while `io_rd` is high with `io_a0`=1 at 6Fh/0Ah. It is high during writes. Writes still update the scratch nibble, and reads return the scratchpad/status byte.
- R7: In write-latch mode, `gp_strobe_n` is low only while `io_wr` is high with `io_a0`=1 at 6Fh/0Ah. That write captures `sd_hi_in` into the latch copy and leaves the scratch nibble unchanged. Reads of the data register return the latch copy and do not assert the strobe.
- R8: In the reserved mode (11), no access asserts the strobe, and the data register behaves as in scratchpad/status mode.
- R9: At primary index 6Fh with any extended index other than 0Ah, no access asserts the strobe in any mode.
- R10: A data-window read of an unmapped index combination returns 0, and `sd_lo_out` is 0 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_a0 | input | 1 | 0 selects the index address, 1 selects the data window |
| io_rd | input | 1 | Host I/O read cycle active |
| io_wr | input | 1 | Host I/O write cycle active |
| sd_lo_in | input | 8 | Host write data, low lane |
| sd_hi_in | input | 8 | High data lane, captured in write-latch mode |
| sd_lo_out | output | 8 | Host read data, low lane |
| vs_a_n | input | 2 | First socket voltage-sense pins {VS2, VS1} |
| vs_b_n | input | 2 | Second socket voltage-sense pins {VS2, VS1} |
| gp_strobe_n | output | 1 | Active-low general-purpose external port strobe |

## Verification
The results of this block fall due at three different times:

- **Same cycle.** The strobe and the read mux are combinational from `io_rd`/`io_wr`, so the bench samples them one nanosecond after it drives the cycle, well before the next rising edge.
- **One edge later.** Index, control, scratch and latch updates take effect at the rising edge that ends a write cycle, so the bench reads them back in a later access.
- **Two edges later.** Sense-pin levels pass through two flops. The bench changes a pin on a falling edge and reads once after one rising edge, expecting the old level. It reads again after the second rising edge, expecting the new level.

// File: rtl/xdp_pkg.sv
package xdp_pkg;
    // Shared widths, index constants and the mode encoding of the external data port.
    localparam int unsigned DW        = 8;
    localparam int unsigned VSW       = 2;
    localparam logic [DW-1:0] PIDX_EXT  = 8'h6E;
    localparam logic [DW-1:0] PIDX_WIN  = 8'h6F;
    localparam logic [DW-1:0] XIDX_DATA = 8'h0A;
    localparam logic [DW-1:0] XIDX_CTRL = 8'h0B;
    localparam int unsigned MODE_HI   = 4;
    localparam int unsigned MODE_LO   = 3;

    typedef enum logic [1:0] {
        XDP_SCRATCH = 2'b00,
        XDP_RDPORT  = 2'b01,
        XDP_WRLATCH = 2'b10,
        XDP_RSVD    = 2'b11
    } xdp_mode_e;
endpackage

// File: rtl/xdp_decode.sv
// xdp_decode: holds the primary and extended index registers and flags which
// register the data window currently addresses.
// Assumes io_wr is a single-cycle-or-longer level; one write per cycle is applied.
module xdp_decode
    import xdp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_a0,
    input  logic          io_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] pidx_q,
    output logic [DW-1:0] xidx_q,
    output logic          at_ext,
    output logic          at_data,
    output logic          at_ctrl
);
    // Decode of the current index pair.
    always_comb begin
        at_ext  = (pidx_q == PIDX_EXT);
        at_data = (pidx_q == PIDX_WIN) && (xidx_q == XIDX_DATA);
        at_ctrl = (pidx_q == PIDX_WIN) && (xidx_q == XIDX_CTRL);
    end

    // Primary index load from the index address.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pidx_q <= '0;
        else if (io_wr && !io_a0)   pidx_q <= wdata;
    end

    // Extended index load through the 6Eh data window.
    always_ff @(posedge clk) begin
        if (!rst_n)                          xidx_q <= '0;
        else if (io_wr && io_a0 && at_ext)   xidx_q <= wdata;
    end
endmodule

// File: rtl/xdp_sync.sv
// xdp_sync: multi-stage synchronizer for asynchronous sense pins.
// Assumes the pins are quasi-static; no glitch filtering is done.
module xdp_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each later stage re-samples its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xdp_core.sv
// xdp_core: control register, scratch nibble, latch copy and strobe generation.
// Assumes qualified accesses (data_rd, data_wr, ctrl_wr) are already decoded
// from the index state and never overlap a read with a write.
module xdp_core
    import xdp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            data_rd,
    input  logic            data_wr,
    input  logic            ctrl_wr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   sd_hi_in,
    output logic [DW-1:0]   ctrl_q,
    output logic [DW/2-1:0] scratch_q,
    output logic [DW-1:0]   latch_q,
    output xdp_mode_e       mode,
    output logic            gp_strobe_n
);
    // Mode field taken from the two strobe-enable control bits.
    assign mode = xdp_mode_e'({ctrl_q[MODE_HI], ctrl_q[MODE_LO]});

    // Strobe follows the qualifying host cycle for the active port mode only.
    always_comb begin
        gp_strobe_n = 1'b1;
        if ((mode == XDP_RDPORT  && data_rd) ||
            (mode == XDP_WRLATCH && data_wr))
            gp_strobe_n = 1'b0;
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata;
    end

    // Scratch nibble updates on data writes outside write-latch mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch_q <= '0;
        else if (data_wr && mode != XDP_WRLATCH)
            scratch_q <= wdata[DW-1:DW/2];
    end

    // Latch copy of the high lane captured on a strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (data_wr && mode == XDP_WRLATCH)
            latch_q <= sd_hi_in;
    end
endmodule

// File: rtl/xdata_port.sv
// xdata_port: indexed external data port register slice with three port modes.
// Assumes io_rd and io_wr are never high together; read data is driven only
// while io_rd is high.
module xdata_port
    import xdp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_a0,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic [DW-1:0] sd_lo_in,
    input  logic [DW-1:0] sd_hi_in,
    output logic [DW-1:0] sd_lo_out,
    input  logic [1:0]    vs_a_n,
    input  logic [1:0]    vs_b_n,
    output logic          gp_strobe_n
);
    localparam int unsigned SENSEW = 2 * VSW;

    logic [DW-1:0]     pidx_q, xidx_q, ctrl_q, latch_q;
    logic [DW/2-1:0]   scratch_q;
    logic [SENSEW-1:0] sense_q;
    logic              at_ext, at_data, at_ctrl;
    logic              data_rd, data_wr, ctrl_wr;
    xdp_mode_e         mode;

    xdp_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_a0   (io_a0),
        .io_wr   (io_wr),
        .wdata   (sd_lo_in),
        .pidx_q  (pidx_q),
        .xidx_q  (xidx_q),
        .at_ext  (at_ext),
        .at_data (at_data),
        .at_ctrl (at_ctrl)
    );

    xdp_sync #(.WIDTH(SENSEW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vs_b_n, vs_a_n}),
        .q     (sense_q)
    );

    // Qualified data-window accesses.
    assign data_rd = io_rd && io_a0 && at_data;
    assign data_wr = io_wr && io_a0 && at_data;
    assign ctrl_wr = io_wr && io_a0 && at_ctrl;

    xdp_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_rd     (data_rd),
        .data_wr     (data_wr),
        .ctrl_wr     (ctrl_wr),
        .wdata       (sd_lo_in),
        .sd_hi_in    (sd_hi_in),
        .ctrl_q      (ctrl_q),
        .scratch_q   (scratch_q),
        .latch_q     (latch_q),
        .mode        (mode),
        .gp_strobe_n (gp_strobe_n)
    );

    // Read-back mux for the index address and the data window.
    always_comb begin
        sd_lo_out = '0;
        if (io_rd) begin
            if (!io_a0)       sd_lo_out = pidx_q;
            else if (at_ext)  sd_lo_out = xidx_q;
            else if (at_data) sd_lo_out = (mode == XDP_WRLATCH) ? latch_q
                                                                : {scratch_q, sense_q};
            else if (at_ctrl) sd_lo_out = ctrl_q;
        end
    end
endmodule

// File: rtl/xdata_port_chk.sv
// xdata_port_chk: protocol checks on the strobe, latch and reset state,
// attached to every xdata_port instance.
module xdata_port_chk
    import xdp_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          io_rd,
    input logic          io_wr,
    input logic          gp_strobe_n,
    input logic [DW-1:0] sd_hi_in,
    input logic [1:0]    mode,
    input logic [DW-1:0] ctrl_q,
    input logic [DW-1:0] latch_q,
    input logic [3:0]    scratch_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && latch_q == '0 && scratch_q == '0)); // R1
    AST_RD_STROBE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gp_strobe_n && io_rd) |-> (mode == 2'b01)); // R6
    AST_WR_STROBE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gp_strobe_n && io_wr) |-> (mode == 2'b10)); // R7
    AST_STROBE_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !gp_strobe_n |-> (io_rd || io_wr)); // R6
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> gp_strobe_n); // R8
    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gp_strobe_n && io_wr) |=> (latch_q == $past(sd_hi_in))); // R7
    AST_SCRATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!gp_strobe_n && io_wr) |=> $stable(scratch_q)); // R7
endmodule

bind xdata_port xdata_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .gp_strobe_n (gp_strobe_n),
    .sd_hi_in    (sd_hi_in),
    .mode        (mode),
    .ctrl_q      (ctrl_q),
    .latch_q     (latch_q),
    .scratch_q   (scratch_q)
);

// File: tb/test_xdata_port.sv
module test_xdata_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_a0 = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] sd_lo_in = '0, sd_hi_in = '0;
    logic [7:0] sd_lo_out;
    logic [1:0] vs_a_n = '0, vs_b_n = '0;
    logic       gp_strobe_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    xdata_port i_xdata_port (
        .clk(clk), .rst_n(rst_n), .io_a0(io_a0), .io_rd(io_rd), .io_wr(io_wr),
        .sd_lo_in(sd_lo_in), .sd_hi_in(sd_hi_in), .sd_lo_out(sd_lo_out),
        .vs_a_n(vs_a_n), .vs_b_n(vs_b_n), .gp_strobe_n(gp_strobe_n)
    );

    // Fields: ctrl, wdata, hi, {vs_b,vs_a}, expected read, rd strobe low, wr strobe low, pad
    localparam int NV = 7;
    localparam logic [39:0] VEC [NV] = '{
        {8'h00, 8'hA5, 8'h3C, 4'b1001, 8'hA9, 1'b0, 1'b0, 2'b00},
        {8'h00, 8'h5F, 8'h00, 4'b0011, 8'h53, 1'b0, 1'b0, 2'b00},
        {8'h08, 8'hC3, 8'h77, 4'b0110, 8'hC6, 1'b1, 1'b0, 2'b00},
        {8'h10, 8'h12, 8'h9E, 4'b0000, 8'h9E, 1'b0, 1'b1, 2'b00},
        {8'h18, 8'h7B, 8'h44, 4'b1111, 8'h7F, 1'b0, 1'b0, 2'b00},
        {8'h10, 8'hFF, 8'h01, 4'b0000, 8'h01, 1'b0, 1'b1, 2'b00},
        {8'h00, 8'h3A, 8'h00, 4'b0100, 8'h34, 1'b0, 1'b0, 2'b00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One write cycle starting at a falling edge; returns the strobe seen mid-cycle.
    task automatic wr(input logic a0, input logic [7:0] d, input logic [7:0] hi,
                      output logic stb);
        io_a0 = a0; sd_lo_in = d; sd_hi_in = hi; io_wr = 1'b1;
        #1 stb = gp_strobe_n;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // One read cycle starting at a falling edge; returns data and strobe.
    task automatic rd(input logic a0, output logic [7:0] d, output logic stb);
        io_a0 = a0; io_rd = 1'b1;
        #1 begin d = sd_lo_out; stb = gp_strobe_n; end
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic sel(input logic [7:0] xidx, output logic stb);
        logic s;
        wr(1'b0, 8'h6E, 8'h00, s);
        wr(1'b1, xidx, 8'h00, s);
        wr(1'b0, 8'h6F, 8'h00, stb);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        logic s, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 strobe idle", {7'd0, gp_strobe_n}, 8'h01);
        rd(1'b0, d, s);  chk("R1 primary index", d, 8'h00);
        sel(8'h0B, s);
        rd(1'b1, d, s);  chk("R1 control", d, 8'h00);
        sel(8'h0A, s);
        rd(1'b1, d, s);  chk("R1 data", d, 8'h00);

        // R2: index and extended index read-back
        wr(1'b0, 8'h6E, 8'h00, s);
        rd(1'b0, d, s);  chk("R2 primary index", d, 8'h6E);
        wr(1'b1, 8'h5C, 8'h00, s);
        rd(1'b1, d, s);  chk("R2 extended index", d, 8'h5C);

        // Table walk: R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            vs_b_n = v[15:14]; vs_a_n = v[13:12];
            sel(8'h0B, s);
            wr(1'b1, v[39:32], 8'h00, s);
            rd(1'b1, d, s);  chk("R3 control read-back", d, v[39:32]);
            sel(8'h0A, s);
            wr(1'b1, v[31:24], v[23:16], s);
            chk($sformatf("R6/R7/R8 vec%0d write strobe", i), {7'd0, s}, {7'd0, ~v[2]});
            repeat (3) @(negedge clk);
            rd(1'b1, d, s);
            chk($sformatf("R4/R7 vec%0d read data", i), d, v[11:4]);
            chk($sformatf("R6/R8 vec%0d read strobe", i), {7'd0, s}, {7'd0, ~v[3]});
        end

        // R5: two-edge synchronizer latency
        vs_b_n = 2'b00; vs_a_n = 2'b00;
        repeat (3) @(negedge clk);
        vs_a_n = 2'b11;
        @(negedge clk);
        rd(1'b1, d, s);  chk("R5 after one edge", d[3:0], 4'h0);
        rd(1'b1, d, s);  chk("R5 after two edges", d[3:0], 4'h3);

        // R7: scratch kept across a latch-mode write, then visible in scratch mode
        wr(1'b1, 8'h50, 8'h00, s);
        sel(8'h0B, s); wr(1'b1, 8'h10, 8'h00, s);
        sel(8'h0A, s); wr(1'b1, 8'hA0, 8'h11, s);
        chk("R7 write strobe low", {7'd0, s}, 8'h00);
        rd(1'b1, d, s);  chk("R7 latch read", d, 8'h11);
        chk("R7 no strobe on read", {7'd0, s}, 8'h01);
        sel(8'h0B, s2);
        chk("R9 index write no strobe", {7'd0, s2}, 8'h01);
        wr(1'b1, 8'h00, 8'h00, s);
        chk("R9 control write no strobe", {7'd0, s}, 8'h01);
        sel(8'h0A, s);
        rd(1'b1, d, s);  chk("R7 scratch unchanged", d, 8'h53);

        // R4: low nibble writes ignored
        wr(1'b1, 8'h2F, 8'h00, s);
        rd(1'b1, d, s);  chk("R4 low nibble ignored", d, 8'h23);

        // R6: read port mode, strobe not on write; R9 other ext index
        sel(8'h0B, s); wr(1'b1, 8'h08, 8'h00, s);
        rd(1'b1, d, s);  chk("R9 control read no strobe", {7'd0, s}, 8'h01);
        sel(8'h0A, s);
        wr(1'b1, 8'h90, 8'h00, s);
        chk("R6 no strobe on write", {7'd0, s}, 8'h01);
        rd(1'b1, d, s);  chk("R6 scratch via write", d, 8'h93);
        chk("R6 strobe on read", {7'd0, s}, 8'h00);
        sel(8'h0C, s);
        rd(1'b1, d, s);  chk("R9 unmapped ext no strobe", {7'd0, s}, 8'h01);

        // R10: unmapped reads and idle bus
        chk("R10 unmapped ext index", d, 8'h00);
        wr(1'b0, 8'h20, 8'h00, s);
        rd(1'b1, d, s);  chk("R10 unmapped primary", d, 8'h00);
        #1 chk("R10 idle bus", sd_lo_out, 8'h00);

        done = 1'b1;
        summary();
    end
endmodule